// File: doc/BRIEF.md
# CAS latency selector for two memory modules

This block chooses the column-access latency that a memory controller should use when up to two modules share a bus. Each module supplies a bitmap of the latencies it accepts and two minimum cycle times: one for running one half-step faster than its slowest latency, and one for running a full step faster. The block turns each non-zero cycle time into a frequency in MHz with a sequential divider. It removes from each module's bitmap the latencies that cannot run at the present bus speed. It then merges the two reduced sets and reports the lowest latency both modules can use, as a 3-bit controller code.

A start pulse captures all inputs. A fixed number of cycles later, done pulses for one cycle. At the same time cas_code and err take their new values and keep them until the next result. A module whose bitmap is all ones is treated as not fitted and imposes no constraint. If no latency can be agreed, or neither module is fitted, err is raised.

Top module: `cas_lat_sel`

## Requirements
- R1: A cycle-time byte carries whole nanoseconds in bits 7:4 and tenths in bits 3:0. Its frequency is floor(20000 / (hi*10 + lo)) MHz. If the half-step byte is zero, the module's bitmap is used unchanged.
- R2: A bitmap of 0xFF marks a module that is not fitted; its set is empty. A bitmap of 0x00 is also an empty set.
- R3: If the half-step frequency is strictly below the bus speed, only the highest set bit of the bitmap is kept.
- R4: If the half-step frequency is at or above the bus speed, the full-step byte is non-zero and its frequency is at or below the bus speed, the bits at index (highest set bit − 1) and upward are kept. When the highest set bit is bit 0, bit 0 is kept. In every other case the bitmap is not pruned.
- R5: If one pruned set is empty, the lowest set bit of the other is chosen. If both are non-empty, the lowest set bit of their intersection is chosen.
- R6: A chosen bit index 0..7 is output on cas_code as 5, 5, 2, 6, 3, 7, 4, 0 respectively.
- R7: If the intersection is empty, or both sets are empty, err is 1 and cas_code is 0.
- R8: done is a single-cycle pulse 16 clock edges after the edge that samples start. cas_code and err change only together with done and hold their values otherwise.
- R9: A start pulse while a selection is in progress is ignored. Input changes after the sampling edge do not affect the result.
- R10: After reset, done, err and cas_code are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a selection; inputs sampled on this edge |
| bus_mhz | input | 10 | Present memory-bus speed in MHz |
| map_a | input | 8 | Accepted-latency bitmap, module A |
| tck_half_a | input | 8 | Half-step faster minimum cycle time, module A |
| tck_one_a | input | 8 | Full-step faster minimum cycle time, module A |
| map_b | input | 8 | Accepted-latency bitmap, module B |
| tck_half_b | input | 8 | Half-step faster minimum cycle time, module B |
| tck_one_b | input | 8 | Full-step faster minimum cycle time, module B |
| done | output | 1 | One-cycle pulse when a result is ready |
| err | output | 1 | No common latency could be found |
| cas_code | output | 3 | Encoded latency for the controller |

## Verification
Every fault inside the block shows at the ports by the single done pulse of the affected selection. A divider that stops or runs too long moves or removes the done pulse, so that pulse is checked on every cycle. A wrong quotient shows up only when the bus speed is near the converted frequency. The bench therefore places cases exactly at, one below and one above the threshold, so that a comparison that is off by one changes the chosen code. Held outputs are compared against the last expected result on every cycle between pulses. A state machine that restarts on a stray start, or a datapath that reads live inputs instead of the captured ones, changes a result within the same selection.

// File: rtl/cas_sel_pkg.sv
package cas_sel_pkg;

    localparam int MAP_W    = 8;
    localparam int IDX_W    = $clog2(MAP_W);
    localparam int TCK_W    = 8;
    localparam int DEN_W    = 8;
    localparam int RATE_NUM = 20000;
    localparam int QUO_W    = $clog2(RATE_NUM + 1);
    localparam int NMOD     = 2;

    typedef logic [MAP_W-1:0] cas_map_t;
    typedef logic [QUO_W-1:0] mhz_t;

    localparam cas_map_t NOT_FITTED = '1;

    typedef struct packed {
        cas_map_t         map;
        logic [TCK_W-1:0] tck_half;
        logic [TCK_W-1:0] tck_one;
    } mod_desc_t;

    typedef struct packed {
        logic       err;
        logic [2:0] code;
    } cas_res_t;

    typedef enum logic [0:0] {ST_IDLE, ST_RUN} sel_state_e;

    // nanoseconds*10 + tenths; worst case 15*10+15 fits in DEN_W bits
    function automatic logic [DEN_W-1:0] tck_denom(input logic [TCK_W-1:0] b);
        return DEN_W'(b[7:4]) * DEN_W'(10) + DEN_W'(b[3:0]);
    endfunction

    function automatic logic [IDX_W-1:0] top_bit(input cas_map_t m);
        logic [IDX_W-1:0] idx;
        idx = '0;
        for (int i = 0; i < MAP_W; i++)
            if (m[i]) idx = IDX_W'(i);
        return idx;
    endfunction

    function automatic logic [IDX_W-1:0] low_bit(input cas_map_t m);
        logic [IDX_W-1:0] idx;
        idx = '0;
        for (int i = MAP_W - 1; i >= 0; i--)
            if (m[i]) idx = IDX_W'(i);
        return idx;
    endfunction

    function automatic cas_map_t keep_from(input logic [IDX_W-1:0] idx);
        cas_map_t all;
        all = '1;
        return all << idx;
    endfunction

    function automatic logic [2:0] lat_encode(input logic [IDX_W-1:0] idx);
        logic [2:0] c;
        case (idx)
            3'd0:    c = 3'd5;
            3'd1:    c = 3'd5;
            3'd2:    c = 3'd2;
            3'd3:    c = 3'd6;
            3'd4:    c = 3'd3;
            3'd5:    c = 3'd7;
            3'd6:    c = 3'd4;
            default: c = 3'd0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/cas_rate_div.sv
module cas_rate_div #(
    parameter int NUM_W = 15,
    parameter int DEN_W = 8,
    parameter int NUM   = 20000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  logic [DEN_W-1:0] den,
    output logic [NUM_W-1:0] quo,
    output logic             vld
);
    localparam int CNT_W = $clog2(NUM_W + 1);

    logic [NUM_W-1:0] q_r;
    logic [DEN_W-1:0] r_r;
    logic [DEN_W-1:0] d_r;
    logic [CNT_W-1:0] cnt_r;
    logic             run_r;
    logic             vld_r;

    logic [DEN_W:0]   r_sh;
    logic             ge;
    logic [DEN_W-1:0] diff;

    always_comb begin
        r_sh = {r_r, q_r[NUM_W-1]};
        ge   = r_sh >= {1'b0, d_r};
        diff = r_sh[DEN_W-1:0] - d_r;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q_r   <= '0;
            r_r   <= '0;
            d_r   <= '0;
            cnt_r <= '0;
            run_r <= 1'b0;
            vld_r <= 1'b0;
        end else begin
            vld_r <= 1'b0;
            if (go) begin
                q_r   <= NUM_W'(NUM);
                r_r   <= '0;
                d_r   <= den;
                cnt_r <= CNT_W'(NUM_W);
                run_r <= 1'b1;
            end else if (run_r) begin
                q_r   <= {q_r[NUM_W-2:0], ge};
                r_r   <= ge ? diff : r_sh[DEN_W-1:0];
                cnt_r <= cnt_r - 1'b1;
                if (cnt_r == CNT_W'(1)) begin
                    run_r <= 1'b0;
                    vld_r <= 1'b1;
                end
            end
        end
    end

    assign quo = q_r;
    assign vld = vld_r;
endmodule

// File: rtl/cas_prune.sv
module cas_prune
    import cas_sel_pkg::*;
#(
    parameter int BUS_W = 10
) (
    input  cas_map_t          map,
    input  logic [TCK_W-1:0]  tck_half,
    input  logic [TCK_W-1:0]  tck_one,
    input  mhz_t              spd_half,
    input  mhz_t              spd_one,
    input  logic [BUS_W-1:0]  bus,
    output cas_map_t          keep
);
    logic [IDX_W-1:0] hi_idx;
    logic [IDX_W-1:0] next_idx;
    mhz_t             bus_x;

    always_comb begin
        hi_idx   = top_bit(map);
        next_idx = (hi_idx == '0) ? '0 : hi_idx - 1'b1;
        bus_x    = QUO_W'(bus);
        if (map == NOT_FITTED)
            keep = '0;
        else if (tck_half == '0)
            keep = map;
        else if (spd_half < bus_x)
            keep = map & keep_from(hi_idx);
        else if ((tck_one != '0) && (spd_one <= bus_x))
            keep = map & keep_from(next_idx);
        else
            keep = map;
    end
endmodule

// File: rtl/cas_merge.sv
module cas_merge
    import cas_sel_pkg::*;
(
    input  cas_map_t keep0,
    input  cas_map_t keep1,
    output cas_res_t res
);
    cas_map_t pick;
    logic     fail;

    always_comb begin
        pick = '0;
        fail = 1'b0;
        if ((keep0 == '0) && (keep1 == '0))
            fail = 1'b1;
        else if (keep0 == '0)
            pick = keep1;
        else if (keep1 == '0)
            pick = keep0;
        else begin
            pick = keep0 & keep1;
            fail = (pick == '0);
        end
        res.err  = fail;
        res.code = fail ? 3'd0 : lat_encode(low_bit(pick));
    end
endmodule

// File: rtl/cas_lat_sel.sv
module cas_lat_sel
    import cas_sel_pkg::*;
#(
    parameter int BUS_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [BUS_W-1:0] bus_mhz,
    input  logic [7:0]       map_a,
    input  logic [7:0]       tck_half_a,
    input  logic [7:0]       tck_one_a,
    input  logic [7:0]       map_b,
    input  logic [7:0]       tck_half_b,
    input  logic [7:0]       tck_one_b,
    output logic             done,
    output logic             err,
    output logic [2:0]       cas_code
);
    sel_state_e             st;
    mod_desc_t [NMOD-1:0]   desc_in;
    mod_desc_t [NMOD-1:0]   desc_r;
    logic [BUS_W-1:0]       bus_r;
    logic                   go;
    mhz_t                   spd_h [NMOD];
    mhz_t                   spd_o [NMOD];
    logic [NMOD-1:0]        vld_h;
    logic [NMOD-1:0]        vld_o;
    cas_map_t               keep [NMOD];
    cas_res_t               res;
    cas_res_t               res_r;
    logic                   done_r;
    logic                   all_vld;

    assign desc_in[0] = {map_a, tck_half_a, tck_one_a};
    assign desc_in[1] = {map_b, tck_half_b, tck_one_b};
    assign go         = start && (st == ST_IDLE);
    assign all_vld    = (&vld_h) && (&vld_o);

    for (genvar g = 0; g < NMOD; g++) begin : g_mod
        cas_rate_div #(.NUM_W(QUO_W), .DEN_W(DEN_W), .NUM(RATE_NUM)) u_div_half (
            .clk (clk),
            .rst (rst),
            .go  (go),
            .den (tck_denom(desc_in[g].tck_half)),
            .quo (spd_h[g]),
            .vld (vld_h[g])
        );
        cas_rate_div #(.NUM_W(QUO_W), .DEN_W(DEN_W), .NUM(RATE_NUM)) u_div_one (
            .clk (clk),
            .rst (rst),
            .go  (go),
            .den (tck_denom(desc_in[g].tck_one)),
            .quo (spd_o[g]),
            .vld (vld_o[g])
        );
        cas_prune #(.BUS_W(BUS_W)) u_prune (
            .map      (desc_r[g].map),
            .tck_half (desc_r[g].tck_half),
            .tck_one  (desc_r[g].tck_one),
            .spd_half (spd_h[g]),
            .spd_one  (spd_o[g]),
            .bus      (bus_r),
            .keep     (keep[g])
        );
    end

    cas_merge u_merge (
        .keep0 (keep[0]),
        .keep1 (keep[1]),
        .res   (res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            desc_r <= '0;
            bus_r  <= '0;
            res_r  <= '0;
            done_r <= 1'b0;
        end else begin
            done_r <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (start) begin
                        desc_r <= desc_in;
                        bus_r  <= bus_mhz;
                        st     <= ST_RUN;
                    end
                end
                default: begin
                    if (all_vld) begin
                        res_r  <= res;
                        done_r <= 1'b1;
                        st     <= ST_IDLE;
                    end
                end
            endcase
        end
    end

    assign done     = done_r;
    assign err      = res_r.err;
    assign cas_code = res_r.code;
endmodule

// File: rtl/cas_lat_sel_chk.sv
module cas_lat_sel_chk #(
    parameter int LAT = 16
) (
    input logic       clk,
    input logic       rst,
    input logic       start,
    input logic       busy,
    input logic       done,
    input logic       err,
    input logic [2:0] cas_code
);
    localparam int CW = $clog2(LAT + 1) + 1;
    logic [CW-1:0] run_cnt;

    always_ff @(posedge clk) begin
        if (rst || !busy)
            run_cnt <= '0;
        else if (run_cnt != '1)
            run_cnt <= run_cnt + 1'b1;
    end

    // R8: done lasts a single cycle
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8: outputs move only with done
    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(cas_code) && $stable(err)));

    // R8: a selection never runs past its fixed latency
    p_latency_r8: assert property (@(posedge clk) disable iff (rst)
        busy |-> (run_cnt < CW'(LAT)));

    // R8: done follows a running selection
    p_done_after_run_r8: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(busy) && !busy));

    // R7: an error carries code zero
    p_err_code_r7: assert property (@(posedge clk) disable iff (rst)
        err |-> (cas_code == 3'd0));

    // R9: an idle start always begins a selection
    p_start_r9: assert property (@(posedge clk) disable iff (rst)
        (!busy && start) |=> busy);
endmodule

bind cas_lat_sel cas_lat_sel_chk #(.LAT(cas_sel_pkg::QUO_W + 1)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .busy     (st == cas_sel_pkg::ST_RUN),
    .done     (done),
    .err      (err),
    .cas_code (cas_code)
);

// File: tb/sim_cas_lat_sel.sv
module sim_cas_lat_sel;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [9:0] bus_mhz = '0;
    logic [7:0] map_a = '0, tck_half_a = '0, tck_one_a = '0;
    logic [7:0] map_b = '0, tck_half_b = '0, tck_one_b = '0;
    logic       done, err;
    logic [2:0] cas_code;

    int checks = 0;
    int fails  = 0;
    int held_code = 0;
    int held_err  = 0;

    always #5 clk = ~clk;

    cas_lat_sel u0 (
        .clk(clk), .rst(rst), .start(start), .bus_mhz(bus_mhz),
        .map_a(map_a), .tck_half_a(tck_half_a), .tck_one_a(tck_one_a),
        .map_b(map_b), .tck_half_b(tck_half_b), .tck_one_b(tck_one_b),
        .done(done), .err(err), .cas_code(cas_code)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int mhz(input int b);
        return 20000 / ((b >> 4) * 10 + (b & 15));
    endfunction

    function automatic int reduce(input int m, input int a, input int b, input int bus);
        int top = 0;
        if (m == 255 || m == 0) return 0;
        if (a == 0) return m;
        for (int i = 0; i < 8; i++) if ((m >> i) & 1) top = i;
        if (mhz(a) < bus) return m & ((255 << top) & 255);
        if (b != 0 && mhz(b) <= bus) return m & ((255 << ((top > 0) ? top - 1 : 0)) & 255);
        return m;
    endfunction

    task automatic model(input int m0, a0, b0, m1, a1, b1, bus, output int e_err, output int e_code);
        int enc[8] = '{5, 5, 2, 6, 3, 7, 4, 0};
        int s0, s1, p, lo;
        s0 = reduce(m0, a0, b0, bus);
        s1 = reduce(m1, a1, b1, bus);
        if (s0 == 0 && s1 == 0) p = 0;
        else if (s0 == 0) p = s1;
        else if (s1 == 0) p = s0;
        else p = s0 & s1;
        e_err = (p == 0) ? 1 : 0;
        e_code = 0;
        if (p != 0) begin
            lo = 0;
            for (int i = 7; i >= 0; i--) if ((p >> i) & 1) lo = i;
            e_code = enc[lo];
        end
    endtask

    // starts at a negedge; compares the ports on every cycle of the selection
    task automatic run(input int m0, a0, b0, m1, a1, b1, bus, input string tag, input bit poke);
        int e_err, e_code;
        model(m0, a0, b0, m1, a1, b1, bus, e_err, e_code);
        map_a = m0[7:0]; tck_half_a = a0[7:0]; tck_one_a = b0[7:0];
        map_b = m1[7:0]; tck_half_b = a1[7:0]; tck_one_b = b1[7:0];
        bus_mhz = bus[9:0];
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k <= 17; k++) begin
            chk("R8 done timing", int'(done), (k == 16) ? 1 : 0);
            if (k == 16) begin
                chk({tag, " code"}, int'(cas_code), e_code);
                chk({tag, " err"}, int'(err), e_err);
                held_code = e_code;
                held_err  = e_err;
            end else begin
                chk("R8 held code", int'(cas_code), held_code);
                chk("R8 held err", int'(err), held_err);
            end
            if (poke && k == 4) begin
                // R9: stray start and changed inputs during a selection
                start = 1'b1; map_a = 8'h01; map_b = 8'hFF;
                tck_half_a = 8'h00; bus_mhz = 10'd100;
            end
            if (poke && k == 5) start = 1'b0;
            @(negedge clk);
        end
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL R8 watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R10 done", int'(done), 0);
        chk("R10 err", int'(err), 0);
        chk("R10 code", int'(cas_code), 0);

        run(8'h1C, 8'h60, 8'h75, 8'hFF, 8'h00, 8'h00, 300, "R4 full-step prune", 1'b1);
        run(8'h1C, 8'h75, 8'h00, 8'hFF, 8'h00, 8'h00, 300, "R3 half-step too slow", 1'b0);
        run(8'h1C, 8'h00, 8'h75, 8'hFF, 8'h00, 8'h00, 300, "R1 zero half-step byte", 1'b0);
        run(8'h1C, 8'h50, 8'h60, 8'hFF, 8'h00, 8'h00, 300, "R4 full-step fast enough", 1'b0);
        run(8'h1C, 8'h50, 8'h50, 8'hFF, 8'h00, 8'h00, 400, "R4 speed equal to bus", 1'b0);
        run(8'h1C, 8'h60, 8'h00, 8'hFF, 8'h00, 8'h00, 334, "R1 floor below bus", 1'b0);
        run(8'h1C, 8'h60, 8'h00, 8'hFF, 8'h00, 8'h00, 333, "R1 floor equal bus", 1'b0);
        run(8'h01, 8'h50, 8'h50, 8'hFF, 8'h00, 8'h00, 400, "R4 top bit zero", 1'b0);
        run(8'h0C, 8'h00, 8'h00, 8'h18, 8'h00, 8'h00, 300, "R5 intersection", 1'b0);
        run(8'h04, 8'h00, 8'h00, 8'h10, 8'h00, 8'h00, 300, "R7 disjoint", 1'b0);
        run(8'hFF, 8'h00, 8'h00, 8'hFF, 8'h00, 8'h00, 300, "R7 both absent", 1'b0);
        run(8'h1C, 8'h75, 8'h00, 8'h0C, 8'h00, 8'h00, 300, "R7 pruned then disjoint", 1'b0);
        run(8'h00, 8'h00, 8'h00, 8'h08, 8'h00, 8'h00, 300, "R2 empty map", 1'b0);
        run(8'h30, 8'h00, 8'h00, 8'hFF, 8'h75, 8'h01, 300, "R2 absent B ignored", 1'b0);
        for (int i = 0; i < 8; i++)
            run(8'hFF, 8'h00, 8'h00, 1 << i, 8'h00, 8'h00, 200, "R6 encoding", 1'b0);
        run(8'h1C, 8'h60, 8'h75, 8'h1C, 8'h75, 8'h00, 300, "R5 both pruned", 1'b1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule